// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block multiplies an N×N-row-by-K matrix A with a K-by-N matrix B on a square grid of multiply-accumulate cells. Every cell owns one element of the product and keeps its running sum locally. Operands travel through the grid: A values move one cell to the right per clock, and B values move one cell down per clock. Edge delay lanes stagger the entry of each A row and each B column, so the two factors of every product term reach the correct cell in the same cycle. The active cells form a diagonal front that moves from the top-left corner to the bottom-right corner.

A run begins with a one-cycle start pulse. The cycle that carries start also carries inner-dimension step 0. Steps 1 to K−1 follow on the next consecutive cycles. On each of these cycles the caller presents column k of A on one bus and row k of B on the other. A fixed number of cycles after start, the done flag rises. All accumulators are then visible at once on a flat result bus, and they stay there until the next start.

Top module: `systolic_mm`

## Requirements
- R1: A start pulse discards all accumulator and operand-pipeline contents, including those of a run that is still in progress, so the new result depends only on the new operands.
- R2: Step k is sampled on the k-th rising edge after the one that samples start, where the start edge itself is step 0. Lane i of `a_col` (bits [i*DW +: DW]) holds A[i][k]. Lane j of `b_row` (bits [j*DW +: DW]) holds B[k][j].
- R3: After done rises, `c_flat` bits [(i*N+j)*AW +: AW] hold the signed sum over k of A[i][k]·B[k][j] as a two's-complement number.
- R4: Done goes high right after the (2N+K−2)-th rising edge, counting the edge that samples start as the first, and not earlier.
- R5: Once done is high, done and `c_flat` hold steady until the next start. Values on `a_col` and `b_row` outside the K sampled steps have no effect on the result.
- R6: While done is low, including after reset, `c_flat` reads all zeros.
- R7: The edge that samples start drives done low.
- R8: Operands are signed DW-bit values. The extreme products (−128·−128 and −128·127, accumulated K times) give exact results.
- R9: With A padded from [[2,1],[0,3]] and B from [[1,4],[2,1]] (all other entries zero), the top-left 2×2 of the result is [[4,9],[6,3]], and the remaining elements are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run; the same cycle carries step 0 |
| a_col | input | N*DW | Column k of A, one signed lane per row |
| b_row | input | N*DW | Row k of B, one signed lane per column |
| done | output | 1 | High while the result is complete |
| c_flat | output | N*N*AW | All accumulators, row-major, zero while done is low |

## Verification
The hardest situation to create is a start pulse that arrives while a previous run is still moving operands through the grid. At that moment the skew lanes and cell registers hold live, nonzero data that must not reach the new sums. The bench creates this case on purpose. It aborts random runs at varying depths, sometimes in the middle of the input window and sometimes during the drain, and starts a fresh run on the very next cycle. It then checks every element of the new product. After each window closes, random data stays on the buses so that any leak of unsampled values would show up in the result.

// File: rtl/sa_pkg.sv
package sa_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_e;
endpackage

// File: rtl/sa_ctrl.sv
module sa_ctrl
    import sa_pkg::*;
#(
    parameter int N = 3,
    parameter int K = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic feed_en,
    output logic done
);
    localparam int LAST = 2 * N + K - 3;
    localparam int CW   = $clog2(LAST + 2);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt = CW'(1);
            st_d.ph  = (LAST == 0) ? PH_DONE : PH_RUN;
        end else if (st_q.ph == PH_RUN) begin
            if (st_q.cnt == CW'(LAST)) begin
                st_d.ph = PH_DONE;
            end
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign feed_en = start || ((st_q.ph == PH_RUN) && (st_q.cnt < CW'(K)));
    assign done    = (st_q.ph == PH_DONE);
endmodule

// File: rtl/sa_skew.sv
module sa_skew #(
    parameter int DW    = 8,
    parameter int DEPTH = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] sr;
    } skew_t;

    skew_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sr[0] = din;
        for (int s = 1; s < DEPTH; s++) begin
            st_d.sr[s] = clr ? '0 : st_q.sr[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = clr ? '0 : st_q.sr[DEPTH-1];
endmodule

// File: rtl/sa_pe.sv
module sa_pe #(
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] b_out,
    output logic [AW-1:0] acc
);
    localparam int PW = 2 * DW;

    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [AW-1:0] acc;
    } pe_t;

    pe_t                 st_d, st_q;
    logic signed [PW-1:0] prod;
    logic signed [AW-1:0] prod_ext;
    logic signed [AW-1:0] base;

    always_comb begin
        prod     = $signed(a_in) * $signed(b_in);
        prod_ext = AW'(prod);
        base     = clr ? '0 : $signed(st_q.acc);
        st_d     = st_q;
        st_d.a   = a_in;
        st_d.b   = b_in;
        st_d.acc = base + prod_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_out = st_q.a;
    assign b_out = st_q.b;
    assign acc   = st_q.acc;
endmodule

// File: rtl/systolic_mm.sv
module systolic_mm #(
    parameter int N  = 3,
    parameter int K  = 4,
    parameter int DW = 8,
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N*DW-1:0]   a_col,
    input  logic [N*DW-1:0]   b_row,
    output logic              done,
    output logic [N*N*AW-1:0] c_flat
);
    logic          feed_en;
    logic [DW-1:0] a_gate [N];
    logic [DW-1:0] b_gate [N];
    logic [DW-1:0] a_edge [N];
    logic [DW-1:0] b_edge [N];
    logic [DW-1:0] a_in   [N][N];
    logic [DW-1:0] b_in   [N][N];
    logic [DW-1:0] a_out  [N][N];
    logic [DW-1:0] b_out  [N][N];
    logic [AW-1:0] acc    [N][N];

    sa_ctrl #(.N(N), .K(K)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .feed_en (feed_en),
        .done    (done)
    );

    for (genvar l = 0; l < N; l++) begin : g_lane
        assign a_gate[l] = feed_en ? a_col[l*DW +: DW] : '0;
        assign b_gate[l] = feed_en ? b_row[l*DW +: DW] : '0;
        if (l == 0) begin : g_direct
            assign a_edge[l] = a_gate[l];
            assign b_edge[l] = b_gate[l];
        end else begin : g_delay
            sa_skew #(.DW(DW), .DEPTH(l)) u_skew_a (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (start),
                .din   (a_gate[l]),
                .dout  (a_edge[l])
            );
            sa_skew #(.DW(DW), .DEPTH(l)) u_skew_b (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (start),
                .din   (b_gate[l]),
                .dout  (b_edge[l])
            );
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (j == 0) begin : g_a_edge
                assign a_in[i][j] = a_edge[i];
            end else begin : g_a_link
                assign a_in[i][j] = start ? '0 : a_out[i][j-1];
            end
            if (i == 0) begin : g_b_edge
                assign b_in[i][j] = b_edge[j];
            end else begin : g_b_link
                assign b_in[i][j] = start ? '0 : b_out[i-1][j];
            end

            sa_pe #(.DW(DW), .AW(AW)) u_pe (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (start),
                .a_in  (a_in[i][j]),
                .b_in  (b_in[i][j]),
                .a_out (a_out[i][j]),
                .b_out (b_out[i][j]),
                .acc   (acc[i][j])
            );

            assign c_flat[(i*N+j)*AW +: AW] = done ? acc[i][j] : '0;
        end
    end
endmodule

// File: rtl/sa_chk.sv
module sa_chk #(
    parameter int N  = 3,
    parameter int K  = 4,
    parameter int AW = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic [N*N*AW-1:0] c_flat
);
    localparam int LAST = 2 * N + K - 3;

    logic [15:0] since_start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_start <= '0;
        end else if (start) begin
            since_start <= 16'd1;
        end else if (since_start != 16'hFFFF) begin
            since_start <= since_start + 16'd1;
        end
    end

    assert_done_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (since_start == 16'(LAST + 1)));

    assert_start_clears_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (LAST != 0)) |=> !done);

    assert_result_hidden_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (c_flat == '0));

    assert_done_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> $stable(c_flat));
endmodule

bind systolic_mm sa_chk #(.N(N), .K(K), .AW(AW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .c_flat (c_flat)
);

// File: tb/tb_systolic_mm.sv
module tb_systolic_mm;
    localparam int N      = 3;
    localparam int K      = 4;
    localparam int DW     = 8;
    localparam int AW     = 32;
    localparam int LAST   = 2 * N + K - 3;
    localparam int PERIOD = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [N*DW-1:0]   a_col = '0;
    logic [N*DW-1:0]   b_row = '0;
    logic              done;
    logic [N*N*AW-1:0] c_flat;

    int  a_m [N][K];
    int  b_m [K][N];
    int  nchk = 0;
    int  nfail = 0;
    bit  reported = 1'b0;

    systolic_mm #(.N(N), .K(K), .DW(DW), .AW(AW)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .a_col  (a_col),
        .b_row  (b_row),
        .done   (done),
        .c_flat (c_flat)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        end
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_c(input int i, input int j);
        int s = 0;
        for (int k = 0; k < K; k++) s += a_m[i][k] * b_m[k][j];
        return s;
    endfunction

    function automatic int got_c(input int i, input int j);
        return $signed(c_flat[(i*N+j)*AW +: AW]);
    endfunction

    task automatic drive_step(input int k);
        for (int l = 0; l < N; l++) begin
            if (k < K) begin
                a_col[l*DW +: DW] = a_m[l][k][DW-1:0];
                b_row[l*DW +: DW] = b_m[k][l][DW-1:0];
            end else begin
                a_col[l*DW +: DW] = DW'($urandom);
                b_row[l*DW +: DW] = DW'($urandom);
            end
        end
    endtask

    // Runs a multiply; stop_at > 0 abandons it after that many edges.
    task automatic run_mat(input int stop_at);
        @(negedge clk);
        start = 1'b1;
        drive_step(0);
        @(posedge clk);
        for (int e = 1; e < LAST + 1; e++) begin
            if (e == stop_at) return;
            @(negedge clk);
            start = 1'b0;
            drive_step(e);
            if (e == LAST) chk(done == 1'b0, "R4 early", done, 0);
            @(posedge clk);
        end
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R4 done", done, 1);
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++)
                chk(got_c(i, j) == exp_c(i, j), req, got_c(i, j), exp_c(i, j));
    endtask

    task automatic fill_rand();
        for (int i = 0; i < N; i++)
            for (int k = 0; k < K; k++) a_m[i][k] = $signed(8'($urandom));
        for (int k = 0; k < K; k++)
            for (int j = 0; j < N; j++) b_m[k][j] = $signed(8'($urandom));
    endtask

    initial begin
        #(PERIOD * 200000);
        nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        logic [N*N*AW-1:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R6 reset done", done, 0);
        chk(c_flat == '0, "R6 reset result", 1, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: padded small example
        for (int i = 0; i < N; i++) for (int k = 0; k < K; k++) a_m[i][k] = 0;
        for (int k = 0; k < K; k++) for (int j = 0; j < N; j++) b_m[k][j] = 0;
        a_m[0][0] = 2; a_m[0][1] = 1; a_m[1][0] = 0; a_m[1][1] = 3;
        b_m[0][0] = 1; b_m[0][1] = 4; b_m[1][0] = 2; b_m[1][1] = 1;
        run_mat(0);
        chk(got_c(0, 0) == 4, "R9 c00", got_c(0, 0), 4);
        chk(got_c(0, 1) == 9, "R9 c01", got_c(0, 1), 9);
        chk(got_c(1, 0) == 6, "R9 c10", got_c(1, 0), 6);
        chk(got_c(1, 1) == 3, "R9 c11", got_c(1, 1), 3);
        check_all("R3 padded");

        // R5: hold with garbage on buses
        held = c_flat;
        for (int c = 0; c < 6; c++) begin
            drive_step(K);
            @(negedge clk);
            chk(done == 1'b1, "R5 done held", done, 1);
            chk(c_flat == held, "R5 result held", 0, 0);
        end

        // R7 / R6: start clears done and hides result
        @(negedge clk);
        fill_rand();
        start = 1'b1;
        drive_step(0);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R7 start clears done", done, 0);
        chk(c_flat == '0, "R6 hidden while running", 1, 0);
        start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R8: extremes
        for (int i = 0; i < N; i++) for (int k = 0; k < K; k++) a_m[i][k] = -128;
        for (int k = 0; k < K; k++) for (int j = 0; j < N; j++) b_m[k][j] = (j == 1) ? 127 : -128;
        run_mat(0);
        check_all("R8 extremes");

        // R2/R3: random products
        for (int r = 0; r < 20; r++) begin
            fill_rand();
            run_mat(0);
            check_all("R2 R3 random");
        end

        // R1: restart in flight at every depth
        for (int s = 1; s <= LAST; s++) begin
            fill_rand();
            for (int i = 0; i < N; i++) a_m[i][0] = 127;
            run_mat(s);
            fill_rand();
            run_mat(0);
            check_all("R1 restart");
        end

        // R1: restart straight after done
        fill_rand();
        run_mat(0);
        fill_rand();
        run_mat(0);
        check_all("R1 back to back");

        report();
        $finish;
    end
endmodule